// File: doc/BRIEF.md
# Ethernet Transmit Frame Builder

This block turns a transmit request from an upper layer into a complete Ethernet frame written into the transmit buffer of an external MAC/PHY chip. The chip sits behind a shared register bus, and the bus is reached through an arbiter. Each request is made of a payload length, a frame type and a destination address. The block answers it in three stages. First it programs the chip's transmit length. Then it opens the transmit buffer and streams the header words, followed by the payload words that it pulls from the upper layer with a read enable. Last, it can issue the send command.

At start-up the block owns the bus until it has read its own station address out of the chip's address registers. It keeps that address and puts it into every header as the source field. The bus moves 16 bits per word, but the chip expects the two bytes of each word in swapped order. The block therefore places the earlier frame byte in the low half of each word. A second transmit waits until the interrupt logic reports that the previous frame has left the chip.

Top module: `txFrameBuilder`

## Requirements
- R1: After reset the block holds `commReq` and, once granted, issues six register reads at addresses 0x10 to 0x15 in increasing order. No register write and no stream word occur before all six reads are done. The byte read from 0x10 is the first byte of the station address on the wire.
- R2: While reset is asserted, `cfgStart`, `wordValid` and `txRe` stay low. When the block is idle, `commReq` is low.
- R3: The first two writes of each frame program the total length, which is the payload length plus 14. The low byte goes to address 0xFC and then the high byte goes to address 0xFD.
- R4: The third write of each frame goes to the buffer-port address 0xF8 with data 0x00. Stream words follow it and only it.
- R5: The header is seven stream words, in this order: three destination words, three source words, then one type word. Each word carries the earlier frame byte in bits 7:0 and the later byte in bits 15:8. The first destination byte is `txDstMac[47:40]`, and the first type byte is `txType[15:8]`.
- R6: The payload is ceil(len/2) stream words, with `wordData` equal to `txData`. `txRe` and `wordValid` rise only in the payload phase and only while `txDataValid` is high. A low `txDataValid` stalls the payload.
- R7: With `SEND_CMD_EN` set (the default), the payload is followed by a write of 0x01 to address 0x02. With it clear, no such write happens.
- R8: After a frame is accepted, `newTx` is ignored until `txDone` pulses. A `txDone` pulse that coincides with a pending `newTx` lets that request be accepted in the same cycle. A `txDone` pulse that arrives during a frame frees the next request.
- R9: Every register access and every stream word occurs while both `commReq` and `commGrant` are high. `commReq` stays high from acceptance through the last access of the frame.
- R10: Only one register access is outstanding at a time. After `cfgStart`, no new `cfgStart` is issued until `cfgAck` has returned.
- R11: A frame with zero payload length consists of the seven header words only, and the length written to the chip is 14.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| newTx | input | 1 | Transmit request from the upper layer |
| txLen | input | 11 | Payload length in bytes |
| txType | input | 16 | Frame type |
| txDstMac | input | 48 | Destination address, first wire byte in bits 47:40 |
| txData | input | 16 | Payload word, already in bus byte order |
| txDataValid | input | 1 | Payload word available |
| txRe | output | 1 | Payload word taken this cycle |
| txDone | input | 1 | Pulse from interrupt logic: previous frame sent |
| commReq | output | 1 | Bus request to the arbiter |
| commGrant | input | 1 | Bus grant from the arbiter |
| cfgStart | output | 1 | Start one register access |
| cfgRead | output | 1 | Access is a read |
| cfgAddr | output | 8 | Register address |
| cfgData | output | 8 | Register write data |
| cfgAck | input | 1 | Register access finished |
| cfgRdData | input | 8 | Read data, valid with `cfgAck` |
| wordValid | output | 1 | Stream word to the transmit buffer |
| wordData | output | 16 | Stream word data |

## Verification
The case that needs care is a `txDone` pulse in the same cycle as the idle state's test of `newTx`. The slot has to be freed and taken again in that one cycle. If it is not, the request is lost. If it is freed but never taken, a second frame can start later. The bench provokes this by holding `newTx` high for twenty cycles without `txDone`, which must leave the bus untouched. It then raises `txDone` for exactly one cycle while `newTx` is still high, and expects the length writes of that frame to follow. A second pulse, sent in the middle of a frame, must let the next request start without waiting.

// File: rtl/txfb_pkg.sv
package txfb_pkg;

  // chip register map used by the builder
  localparam logic [7:0] REG_MAC_BASE = 8'h10;
  localparam logic [7:0] REG_LEN_LO   = 8'hFC;
  localparam logic [7:0] REG_LEN_HI   = 8'hFD;
  localparam logic [7:0] REG_TXBUF    = 8'hF8;
  localparam logic [7:0] REG_TXCTL    = 8'h02;
  localparam logic [7:0] TXCTL_REQ    = 8'h01;

  localparam int MAC_BYTES = 6;
  localparam int HDR_WORDS = 7;
  localparam int HDR_BYTES = 14;

  typedef enum logic [3:0] {
    ST_BOOT_GNT,
    ST_BOOT_ISSUE,
    ST_BOOT_WAIT,
    ST_IDLE,
    ST_TX_GNT,
    ST_CFG_ISSUE,
    ST_CFG_WAIT,
    ST_HDR,
    ST_PAY,
    ST_POST
  } txState_e;

  typedef enum logic [1:0] {
    STEP_LEN_LO,
    STEP_LEN_HI,
    STEP_BUF,
    STEP_CTL
  } cfgStep_e;

  // control -> datapath strobes
  typedef struct packed {
    logic       captureReq;
    logic       macWe;
    logic [2:0] macIdx;
    logic       cntDec;
    logic       hdrSel;
    logic [2:0] hdrIdx;
    cfgStep_e   step;
  } strobe_t;

endpackage

// File: rtl/txfb_datapath.sv
module txfb_datapath
  import txfb_pkg::*;
#(
  parameter int LEN_W = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [LEN_W-1:0] newLen,
  input  logic [15:0]      newType,
  input  logic [47:0]      newDst,
  input  logic [7:0]       rdData,
  input  logic [15:0]      txData,
  output logic [15:0]      wordData,
  output logic [7:0]       cfgData,
  output logic             payZero,
  output logic             payLast
);

  localparam int PAD_W = 16 - LEN_W;

  logic [47:0]      macReg;
  logic [47:0]      dstReg;
  logic [15:0]      typeReg;
  logic [LEN_W-1:0] lenReg;
  logic [LEN_W-1:0] payCnt;
  logic [15:0]      lenTot;
  logic [15:0]      hdrWords [8];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      macReg  <= '0;
      dstReg  <= '0;
      typeReg <= '0;
      lenReg  <= '0;
      payCnt  <= '0;
    end else begin
      if (strb.macWe) begin
        for (int i = 0; i < MAC_BYTES; i++) begin
          if (strb.macIdx == 3'(i)) macReg[47-8*i -: 8] <= rdData;
        end
      end
      if (strb.captureReq) begin
        dstReg  <= newDst;
        typeReg <= newType;
        lenReg  <= newLen;
        payCnt  <= {1'b0, newLen[LEN_W-1:1]} + {{(LEN_W-1){1'b0}}, newLen[0]};
      end else if (strb.cntDec) begin
        payCnt <= payCnt - 1'b1;
      end
    end
  end

  assign payZero = (payCnt == '0);
  assign payLast = (payCnt == {{(LEN_W-1){1'b0}}, 1'b1});

  // header words: earlier wire byte in the low half
  for (genvar k = 0; k < 3; k++) begin : g_hdr
    assign hdrWords[k]   = {dstReg[39-16*k -: 8], dstReg[47-16*k -: 8]};
    assign hdrWords[k+3] = {macReg[39-16*k -: 8], macReg[47-16*k -: 8]};
  end
  assign hdrWords[6] = {typeReg[7:0], typeReg[15:8]};
  assign hdrWords[7] = 16'h0000;

  assign wordData = strb.hdrSel ? hdrWords[strb.hdrIdx] : txData;

  assign lenTot = {{PAD_W{1'b0}}, lenReg} + 16'(HDR_BYTES);

  always_comb begin
    unique case (strb.step)
      STEP_LEN_LO: cfgData = lenTot[7:0];
      STEP_LEN_HI: cfgData = lenTot[15:8];
      STEP_BUF:    cfgData = 8'h00;
      default:     cfgData = TXCTL_REQ;
    endcase
  end

endmodule

// File: rtl/txfb_ctrl.sv
module txfb_ctrl
  import txfb_pkg::*;
#(
  parameter bit SEND_CMD_EN = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       newTx,
  input  logic       txDone,
  input  logic       commGrant,
  input  logic       cfgAck,
  input  logic       txDataValid,
  input  logic       payZero,
  input  logic       payLast,
  output strobe_t    strb,
  output logic       commReq,
  output logic       cfgStart,
  output logic       cfgRead,
  output logic [7:0] cfgAddr,
  output logic       wordValid,
  output logic       txRe
);

  localparam logic [2:0] MAC_LAST = 3'(MAC_BYTES - 1);
  localparam logic [2:0] HDR_LAST = 3'(HDR_WORDS - 1);

  txState_e state, nxtState;
  cfgStep_e step, nxtStep;
  logic [2:0] macIdx, nxtMacIdx;
  logic [2:0] hdrIdx, nxtHdrIdx;
  logic txFree;
  logic accept, macWe, cntDec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_BOOT_GNT;
      step   <= STEP_LEN_LO;
      macIdx <= '0;
      hdrIdx <= '0;
      txFree <= 1'b1;
    end else begin
      state  <= nxtState;
      step   <= nxtStep;
      macIdx <= nxtMacIdx;
      hdrIdx <= nxtHdrIdx;
      if (accept)      txFree <= 1'b0;
      else if (txDone) txFree <= 1'b1;
    end
  end

  always_comb begin
    nxtState  = state;
    nxtStep   = step;
    nxtMacIdx = macIdx;
    nxtHdrIdx = hdrIdx;
    accept    = 1'b0;
    macWe     = 1'b0;
    cntDec    = 1'b0;
    unique case (state)
      ST_BOOT_GNT:   if (commGrant) nxtState = ST_BOOT_ISSUE;
      ST_BOOT_ISSUE: nxtState = ST_BOOT_WAIT;
      ST_BOOT_WAIT: begin
        if (cfgAck) begin
          macWe = 1'b1;
          if (macIdx == MAC_LAST) begin
            nxtState = ST_IDLE;
          end else begin
            nxtMacIdx = macIdx + 1'b1;
            nxtState  = ST_BOOT_ISSUE;
          end
        end
      end
      ST_IDLE: begin
        if (newTx && (txFree || txDone)) begin
          accept   = 1'b1;
          nxtStep  = STEP_LEN_LO;
          nxtState = ST_TX_GNT;
        end
      end
      ST_TX_GNT:    if (commGrant) nxtState = ST_CFG_ISSUE;
      ST_CFG_ISSUE: nxtState = ST_CFG_WAIT;
      ST_CFG_WAIT: begin
        if (cfgAck) begin
          unique case (step)
            STEP_LEN_LO: begin nxtStep = STEP_LEN_HI; nxtState = ST_CFG_ISSUE; end
            STEP_LEN_HI: begin nxtStep = STEP_BUF;    nxtState = ST_CFG_ISSUE; end
            STEP_BUF:    begin nxtHdrIdx = '0;        nxtState = ST_HDR;       end
            default:     nxtState = ST_IDLE;
          endcase
        end
      end
      ST_HDR: begin
        if (hdrIdx == HDR_LAST) nxtState = payZero ? ST_POST : ST_PAY;
        else                    nxtHdrIdx = hdrIdx + 1'b1;
      end
      ST_PAY: begin
        if (txDataValid) begin
          cntDec = 1'b1;
          if (payLast) nxtState = ST_POST;
        end
      end
      ST_POST: begin
        if (SEND_CMD_EN) begin
          nxtStep  = STEP_CTL;
          nxtState = ST_CFG_ISSUE;
        end else begin
          nxtState = ST_IDLE;
        end
      end
      default: nxtState = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (step)
      STEP_LEN_LO: cfgAddr = REG_LEN_LO;
      STEP_LEN_HI: cfgAddr = REG_LEN_HI;
      STEP_BUF:    cfgAddr = REG_TXBUF;
      default:     cfgAddr = REG_TXCTL;
    endcase
    if (state == ST_BOOT_ISSUE) cfgAddr = REG_MAC_BASE + {5'd0, macIdx};
  end

  assign commReq   = (state != ST_IDLE);
  assign cfgStart  = (state == ST_BOOT_ISSUE) || (state == ST_CFG_ISSUE);
  assign cfgRead   = (state == ST_BOOT_ISSUE);
  assign txRe      = (state == ST_PAY) && txDataValid;
  assign wordValid = (state == ST_HDR) || txRe;

  assign strb.captureReq = accept;
  assign strb.macWe      = macWe;
  assign strb.macIdx     = macIdx;
  assign strb.cntDec     = cntDec;
  assign strb.hdrSel     = (state == ST_HDR);
  assign strb.hdrIdx     = hdrIdx;
  assign strb.step       = step;

endmodule

// File: rtl/txFrameBuilder.sv
module txFrameBuilder
  import txfb_pkg::*;
#(
  parameter int LEN_W       = 11,
  parameter bit SEND_CMD_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             newTx,
  input  logic [LEN_W-1:0] txLen,
  input  logic [15:0]      txType,
  input  logic [47:0]      txDstMac,
  input  logic [15:0]      txData,
  input  logic             txDataValid,
  output logic             txRe,
  input  logic             txDone,
  output logic             commReq,
  input  logic             commGrant,
  output logic             cfgStart,
  output logic             cfgRead,
  output logic [7:0]       cfgAddr,
  output logic [7:0]       cfgData,
  input  logic             cfgAck,
  input  logic [7:0]       cfgRdData,
  output logic             wordValid,
  output logic [15:0]      wordData
);

  strobe_t strb;
  logic payZero, payLast;

  txfb_ctrl #(.SEND_CMD_EN(SEND_CMD_EN)) u_ctrl (
    .clk(clk), .rstN(rstN), .newTx(newTx), .txDone(txDone),
    .commGrant(commGrant), .cfgAck(cfgAck), .txDataValid(txDataValid),
    .payZero(payZero), .payLast(payLast), .strb(strb),
    .commReq(commReq), .cfgStart(cfgStart), .cfgRead(cfgRead),
    .cfgAddr(cfgAddr), .wordValid(wordValid), .txRe(txRe)
  );

  txfb_datapath #(.LEN_W(LEN_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .newLen(txLen), .newType(txType),
    .newDst(txDstMac), .rdData(cfgRdData), .txData(txData),
    .wordData(wordData), .cfgData(cfgData), .payZero(payZero), .payLast(payLast)
  );

endmodule

// File: rtl/txfb_checker.sv
module txfb_checker
  import txfb_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        cfgStart,
  input logic [7:0]  cfgAddr,
  input logic [7:0]  cfgData,
  input logic        cfgAck,
  input logic        wordValid,
  input logic [15:0] wordData,
  input logic        txRe,
  input logic [15:0] txData,
  input logic        txDataValid,
  input logic        commReq,
  input logic        commGrant
);

  logic [7:0] lastAddr;
  logic       pend;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastAddr <= 8'h00;
      pend     <= 1'b0;
    end else begin
      if (cfgStart) lastAddr <= cfgAddr;
      if (cfgStart)    pend <= 1'b1;
      else if (cfgAck) pend <= 1'b0;
    end
  end

  // R9
  a_r9_bus_owned: assert property (@(posedge clk) disable iff (!rstN)
    (cfgStart || wordValid) |-> (commReq && commGrant));

  // R6
  a_r6_re_gated: assert property (@(posedge clk) disable iff (!rstN)
    txRe |-> (txDataValid && wordValid && wordData == txData));

  // R10
  a_r10_single: assert property (@(posedge clk) disable iff (!rstN)
    cfgStart |-> !pend);

  // R3
  a_r3_len_order: assert property (@(posedge clk) disable iff (!rstN)
    (cfgStart && cfgAddr == REG_LEN_HI) |-> (lastAddr == REG_LEN_LO));

  // R4
  a_r4_stream_after_buf: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |-> (lastAddr == REG_TXBUF));

  // R7
  a_r7_ctl_value: assert property (@(posedge clk) disable iff (!rstN)
    (cfgStart && cfgAddr == REG_TXCTL) |-> (cfgData == TXCTL_REQ));

endmodule

bind txFrameBuilder txfb_checker u_chk (
  .clk(clk), .rstN(rstN), .cfgStart(cfgStart), .cfgAddr(cfgAddr),
  .cfgData(cfgData), .cfgAck(cfgAck), .wordValid(wordValid),
  .wordData(wordData), .txRe(txRe), .txData(txData),
  .txDataValid(txDataValid), .commReq(commReq), .commGrant(commGrant)
);

// File: tb/sim_txFrameBuilder.sv
`timescale 1ns/1ps
module sim_txFrameBuilder;

  localparam logic [47:0] OWN_MAC = 48'h02_1A_2B_3C_4D_5E;

  typedef struct {
    bit        isCfg;
    bit        rd;
    bit [7:0]  addr;
    bit [15:0] data;
    string     tag;
  } ev_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic newTx = 1'b0;
  logic [10:0] txLen = '0;
  logic [15:0] txType = '0;
  logic [47:0] txDstMac = '0;
  logic [15:0] txData = '0;
  logic txDataValid = 1'b0;
  logic txRe;
  logic txDone = 1'b0;
  logic commReq;
  logic commGrant = 1'b0;
  logic cfgStart, cfgRead;
  logic [7:0] cfgAddr, cfgData;
  logic cfgAck = 1'b0;
  logic [7:0] cfgRdData = '0;
  logic wordValid;
  logic [15:0] wordData;

  int checks = 0;
  int errs = 0;
  int cycles = 0;
  ev_t expQ[$];
  ev_t e;
  bit sawStart = 0;
  bit [7:0] sawAddr = '0;
  bit took = 0;
  bit allValid = 0;
  int ackCnt = 0;
  int gntCnt = 0;
  int payIdx = 0;
  logic [15:0] payBase = '0;

  always #4 clk = ~clk;

  txFrameBuilder u0 (
    .clk(clk), .rstN(rstN), .newTx(newTx), .txLen(txLen), .txType(txType),
    .txDstMac(txDstMac), .txData(txData), .txDataValid(txDataValid),
    .txRe(txRe), .txDone(txDone), .commReq(commReq), .commGrant(commGrant),
    .cfgStart(cfgStart), .cfgRead(cfgRead), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .cfgAck(cfgAck), .cfgRdData(cfgRdData),
    .wordValid(wordValid), .wordData(wordData)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  function automatic logic [15:0] swp(input logic [15:0] w);
    return {w[7:0], w[15:8]};
  endfunction

  function automatic void pushCfg(input bit rd, input logic [7:0] a, input logic [7:0] d, input string tag);
    ev_t x;
    x.isCfg = 1; x.rd = rd; x.addr = a; x.data = {8'h00, d}; x.tag = tag;
    expQ.push_back(x);
  endfunction

  function automatic void pushWord(input logic [15:0] d, input string tag);
    ev_t x;
    x.isCfg = 0; x.rd = 0; x.addr = 0; x.data = d; x.tag = tag;
    expQ.push_back(x);
  endfunction

  // reference model: expected transactions of one frame
  function automatic void pushFrame(input int len, input logic [15:0] typ, input logic [47:0] dst, input logic [15:0] base);
    int tot = len + 14;
    pushCfg(0, 8'hFC, 8'(tot), "R3 len low");
    pushCfg(0, 8'hFD, 8'(tot >> 8), "R3 len high");
    pushCfg(0, 8'hF8, 8'h00, "R4 buffer port");
    for (int k = 0; k < 3; k++) pushWord(swp(dst[47-16*k -: 16]), "R5 dst word");
    for (int k = 0; k < 3; k++) pushWord(swp(OWN_MAC[47-16*k -: 16]), "R5 src word");
    pushWord(swp(typ), "R5 type word");
    for (int i = 0; i < (len + 1) / 2; i++) pushWord(base + 16'(i), "R6 payload");
    pushCfg(0, 8'h02, 8'h01, "R7 send command");
  endfunction

  // monitor: sample away from the active edge
  always @(negedge clk) begin
    sawStart = cfgStart && rstN;
    sawAddr  = cfgAddr;
    took     = txRe && rstN;
    if (rstN) begin
      cycles++;
      if (cycles > 150000) begin
        check(0, "watchdog", cycles, 150000);
        summary();
      end
      if (txRe && !txDataValid) check(0, "R6 txRe without valid", 1, 0);
      if ((cfgStart || wordValid) && !(commReq && commGrant)) check(0, "R9 bus not owned", 0, 1);
      if (cfgStart) begin
        if (expQ.size() == 0) check(0, "R10 unexpected register access", {24'h0, cfgAddr}, 0);
        else begin
          e = expQ.pop_front();
          check(e.isCfg && e.addr == cfgAddr && e.rd == cfgRead && (e.rd || e.data[7:0] == cfgData),
                e.tag, {15'h0, cfgRead, cfgAddr, cfgData}, {15'h0, e.rd, e.addr, e.data[7:0]});
        end
      end
      if (wordValid) begin
        if (expQ.size() == 0) check(0, "R11 unexpected stream word", {16'h0, wordData}, 0);
        else begin
          e = expQ.pop_front();
          check(!e.isCfg && e.data == wordData, e.tag, {16'h0, wordData}, {16'h0, e.data});
        end
      end
    end
  end

  // chip, arbiter and payload source, driven just after the edge
  always @(posedge clk) begin
    #1;
    cfgAck = 1'b0;
    if (sawStart) ackCnt = 2;
    else if (ackCnt > 0) begin
      ackCnt--;
      if (ackCnt == 0) cfgAck = 1'b1;
    end
    if (sawStart) cfgRdData = OWN_MAC[47 - 8*(int'(sawAddr) - 16) -: 8];
    if (!commReq) begin
      commGrant = 1'b0;
      gntCnt = 0;
    end else if (!commGrant) begin
      gntCnt++;
      if (gntCnt >= 2) commGrant = 1'b1;
    end
    if (newTx) payIdx = 0;
    else if (took) payIdx++;
    txData = payBase + 16'(payIdx);
    txDataValid = allValid ? 1'b1 : (($urandom % 3) != 0);
  end

  task automatic setReq(input int len, input logic [15:0] typ, input logic [47:0] dst, input logic [15:0] base);
    pushFrame(len, typ, dst, base);
    @(posedge clk); #2;
    txLen = 11'(len); txType = typ; txDstMac = dst; payBase = base;
    newTx = 1'b1;
  endtask

  task automatic waitAccept();
    do @(negedge clk); while (!commReq);
    @(posedge clk); #2;
    newTx = 1'b0;
  endtask

  task automatic waitEnd(input string tag);
    do @(negedge clk); while (expQ.size() != 0 || commReq);
    check(expQ.size() == 0 && !commReq, tag, expQ.size(), 0);
  endtask

  task automatic pulseDone();
    @(posedge clk); #2;
    txDone = 1'b1;
    @(posedge clk); #2;
    txDone = 1'b0;
  endtask

  initial begin
    bit quiet;
    for (int i = 0; i < 6; i++) pushCfg(1, 8'(8'h10 + i), 8'h00, "R1 station address read");
    repeat (3) @(negedge clk);
    check(!cfgStart && !wordValid && !txRe, "R2 reset outputs", {29'h0, cfgStart, wordValid, txRe}, 0);
    @(posedge clk); #2;
    rstN = 1'b1;

    // R1: boot completes with no other traffic
    do @(negedge clk); while (commReq);
    check(expQ.size() == 0, "R1 boot reads done", expQ.size(), 0);
    repeat (3) @(negedge clk);
    check(!commReq && !txRe, "R2 idle quiet", {30'h0, commReq, txRe}, 0);

    // frame 1: odd length, stalling payload
    setReq(9, 16'h0800, 48'hA1_A2_A3_A4_A5_A6, 16'h1000);
    waitAccept();
    waitEnd("R6 frame 1 complete");

    // R8: blocked until txDone, then txDone in the same cycle as newTx
    setReq(0, 16'h0806, 48'hFF_FF_FF_FF_FF_FF, 16'h0000);
    quiet = 1;
    repeat (20) begin
      @(negedge clk);
      if (commReq || cfgStart) quiet = 0;
    end
    check(quiet, "R8 newTx ignored before txDone", {31'h0, quiet}, 1);
    pulseDone();
    waitAccept();
    check(commReq, "R8 accepted on coincident txDone", {31'h0, commReq}, 1);
    repeat (4) @(posedge clk);
    pulseDone();
    waitEnd("R11 zero-length frame complete");

    // R8: txDone during previous frame frees the slot; max length
    setReq(2047, 16'h86DD, 48'h00_11_22_33_44_55, 16'h4000);
    quiet = 0;
    repeat (5) begin
      @(negedge clk);
      if (commReq) quiet = 1;
    end
    check(quiet, "R8 accepted after txDone mid-frame", {31'h0, quiet}, 1);
    waitAccept();
    waitEnd("R3 max-length frame complete");

    // txDone while idle, then single-byte frame with steady valid
    pulseDone();
    repeat (3) @(posedge clk);
    allValid = 1;
    setReq(1, 16'h1234, 48'h10_20_30_40_50_60, 16'hBEEF);
    waitAccept();
    waitEnd("R6 one-word frame complete");
    repeat (5) @(negedge clk);
    check(!commReq && expQ.size() == 0, "R2 idle after frames", {31'h0, commReq}, 0);
    summary();
  end

endmodule